// File: doc/BRIEF.md
# External Wakeup Interrupt Controller

This block watches 24 external interrupt pins and turns their activity into six interrupt requests for a CPU-side interrupt controller. Each pin goes through a two-flop synchronizer. A per-line trigger code then chooses what counts as an event: an active level (low or high), or a falling, rising or either-direction edge. Events set a sticky pending flag. Software clears that flag by writing a one to its bit.

A mask register decides which pending lines can raise a request. It never stops a flag from being recorded. Lines 0 to 3 each have a dedicated request output. Lines 4 to 7 share a fifth output, and lines 8 to 23 share a sixth. Software reaches all state over a simple single-cycle register bus. Reads are combinational on the selected address, and writes take effect at the clock edge.

Top module: `xint_ctrl`

## Requirements
- R1: Line i has a 4-bit trigger field at bits 4*(i mod 8)+3..4*(i mod 8) of the word at byte address 0x88 + 4*(i/8), so lines 0-7 are at 0x88, 8-15 at 0x8C and 16-23 at 0x90. All 32 bits of these words read back exactly as they were written.
- R2: Code 0 (low level) sets the line's pending flag on every clock in which the synchronized pin is 0. A clear written while the pin stays low therefore has no lasting effect.
- R3: Code 1 (high level) sets the pending flag on every clock in which the synchronized pin is 1.
- R4: Code 2 sets the flag on a 1-to-0 change of the synchronized pin. Code 4 sets it on a 0-to-1 change. Code 6 sets it on a change in either direction.
- R5: Codes 3, 5 and 7 to 15 never set the pending flag, whatever the pin does.
- R6: The pending register is at 0xA8, with line i at bit i. Writing a 1 to a bit clears that flag, and writing 0 leaves it unchanged. When an event and a clear hit the same bit on the same clock, the flag stays set.
- R7: The mask register is at 0xA4, with line i at bit i. A 1 masks the line. A masked line still records its pending flag, and clearing the mask bit then exposes that flag on the output.
- R8: irq_o[k] for k = 0..3 is high exactly when line k is pending and unmasked. irq_o[4] is high when any of lines 4-7 is pending and unmasked. irq_o[5] is high when any of lines 8-23 is pending and unmasked.
- R9: A pin change applied before clock edge k is first visible in the pending register after edge k+2.
- R10: After reset, all trigger words read 0, the mask reads 0x00FFFFFF, pending reads 0 and every irq_o is 0. The synchronizer and history flops start at 1, so pins held high during reset cause no event.
- R11: Any other address reads 0, and a write to it changes nothing. Bits 31..24 of the mask and pending words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 24 | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not selected) |
| irq_o | output | 6 | Request outputs: lines 0-3 direct, group 4-7, group 8-23 |

## Verification
The assertions assume that a bus write holds address and data stable across its clock edge. They also assume that reset is applied once at start-up, with the pins held high. The bench drives the bus and the pins only on the falling clock edge, and it keeps the pins high until reset has been released. Pin changes arrive at arbitrary cycles, including in the same cycle as a clear to the same line. The bench's reference model walks through the two synchronizer stages cycle by cycle, so the edge-versus-clear corner cases are checked rather than avoided.

// File: rtl/xint_pkg.sv
package xint_pkg;

  localparam int TRIG_W = 4;

  typedef enum logic [TRIG_W-1:0] {
    TRG_LOW  = 4'd0,
    TRG_HIGH = 4'd1,
    TRG_FALL = 4'd2,
    TRG_RISE = 4'd4,
    TRG_BOTH = 4'd6
  } trig_e;

  // Decide whether one line sees an event this cycle.
  function automatic logic trig_hit(logic [TRIG_W-1:0] code, logic now_v, logic was_v);
    logic r;
    case (code)
      TRG_LOW:  r = ~now_v;
      TRG_HIGH: r = now_v;
      TRG_FALL: r = was_v & ~now_v;
      TRG_RISE: r = ~was_v & now_v;
      TRG_BOTH: r = was_v ^ now_v;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // Bit mask covering positions lo..hi inclusive.
  function automatic logic [63:0] span_mask(int lo, int hi);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < 64; b++) begin
      if (b >= lo && b <= hi) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2,
  parameter bit RST_V  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= {W{RST_V}};
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/xint_edge.sv
module xint_edge
  import xint_pkg::*;
#(
  parameter int N = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N*TRIG_W-1:0] cfg_i,
  input  logic [N-1:0]        lvl_i,
  output logic [N-1:0]        hit_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign hit_o[i] = trig_hit(cfg_i[i*TRIG_W +: TRIG_W], lvl_i[i], prev_q[i]);
  end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int N         = 24,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int CFG_BASE  = 'h88,
  parameter int MASK_ADDR = 'hA4,
  parameter int PEND_ADDR = 'hA8,
  parameter int N_DIRECT  = 4,
  parameter int MID_HI    = 7,
  parameter int SYNC_STG  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        pin_i,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [N_DIRECT+1:0] irq_o
);
  localparam int FPR  = DW / TRIG_W;
  localparam int NREG = (N + FPR - 1) / FPR;
  localparam logic [N-1:0] MID_MASK = N'(span_mask(N_DIRECT, MID_HI));
  localparam logic [N-1:0] TOP_MASK = N'(span_mask(MID_HI + 1, N - 1));

  logic [DW-1:0]       cfg_q [NREG];
  logic [N*TRIG_W-1:0] cfg_flat;
  logic [N-1:0]        mask_q, pend_q, lvl_w, evt_w, clr_w, live_w;
  logic                wr_w;

  assign wr_w = bus_sel & bus_we;

  xint_sync #(.W(N), .STAGES(SYNC_STG), .RST_V(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl_w)
  );

  for (genvar i = 0; i < N; i++) begin : g_fld
    assign cfg_flat[i*TRIG_W +: TRIG_W] = cfg_q[i / FPR][(i % FPR)*TRIG_W +: TRIG_W];
  end

  xint_edge #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_flat), .lvl_i(lvl_w), .hit_o(evt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NREG; j++) cfg_q[j] <= '0;
    end else begin
      for (int j = 0; j < NREG; j++)
        if (wr_w && bus_addr == AW'(CFG_BASE + 4*j)) cfg_q[j] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        mask_q <= '1;
    else if (wr_w && bus_addr == AW'(MASK_ADDR))       mask_q <= bus_wdata[N-1:0];
  end

  assign clr_w = (wr_w && bus_addr == AW'(PEND_ADDR)) ? bus_wdata[N-1:0] : '0;

  // New events take priority over a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_w) | evt_w;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == AW'(MASK_ADDR)) bus_rdata = DW'(mask_q);
      if (bus_addr == AW'(PEND_ADDR)) bus_rdata = DW'(pend_q);
      for (int j = 0; j < NREG; j++)
        if (bus_addr == AW'(CFG_BASE + 4*j)) bus_rdata = cfg_q[j];
    end
  end

  assign live_w = pend_q & ~mask_q;

  for (genvar k = 0; k < N_DIRECT; k++) begin : g_dir
    assign irq_o[k] = live_w[k];
  end
  assign irq_o[N_DIRECT]   = |(live_w & MID_MASK);
  assign irq_o[N_DIRECT+1] = |(live_w & TOP_MASK);
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
  import xint_pkg::*;
#(
  parameter int N         = 24,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int PEND_ADDR = 'hA8,
  parameter int N_DIRECT  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic [N-1:0]        evt,
  input logic [N-1:0]        pend,
  input logic [N-1:0]        mask,
  input logic [N*TRIG_W-1:0] cfg,
  input logic [N_DIRECT+1:0] irq
);
  logic pend_wr;
  assign pend_wr = bus_sel && bus_we && bus_addr == AW'(PEND_ADDR);

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pend & $past(bus_wdata[N-1:0]) & ~$past(evt)) == '0));

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(evt)) == $past(evt)));

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == '0));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> (irq == '0));

  for (genvar i = 0; i < N; i++) begin : g_rsv
    // R5
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg[i*TRIG_W +: TRIG_W] inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd6}) |-> !evt[i]);
  end
endmodule

bind xint_ctrl xint_ctrl_chk #(
  .N(N), .AW(AW), .DW(DW), .PEND_ADDR(PEND_ADDR), .N_DIRECT(N_DIRECT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt(evt_w), .pend(pend_q),
  .mask(mask_q), .cfg(cfg_flat), .irq(irq_o)
);

// File: tb/xint_ctrl_bench.sv
module xint_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pin = '1;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq;

  int n_chk = 0, n_bad = 0;

  // reference state
  bit [23:0] m_s1, m_s2, m_prev, m_pend, m_mask;
  bit [3:0]  m_cfg [24];
  bit [23:0] cur_pins;

  always #10 clk = ~clk;

  xint_ctrl u_xint_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  function automatic bit b_hit(bit [3:0] c, bit cur, bit old);
    if (c == 4'd0) return !cur;
    if (c == 4'd1) return cur;
    if (c == 4'd2) return old && !cur;
    if (c == 4'd4) return !old && cur;
    if (c == 4'd6) return old != cur;
    return 1'b0;
  endfunction

  function automatic bit [31:0] b_read(bit [7:0] a);
    bit [31:0] v = '0;
    if (a == 8'hA4) v = {8'h0, m_mask};
    else if (a == 8'hA8) v = {8'h0, m_pend};
    else if (a == 8'h88 || a == 8'h8C || a == 8'h90) begin
      int r = (a - 8'h88) / 4;
      for (int k = 0; k < 8; k++) v[4*k +: 4] = m_cfg[8*r + k];
    end
    return v;
  endfunction

  function automatic bit [5:0] b_irq();
    bit [23:0] on = m_pend & ~m_mask;
    return {|on[23:8], |on[7:4], on[3], on[2], on[1], on[0]};
  endfunction

  task automatic check(string req, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Starts and ends just after a falling edge.
  task automatic cycle(bit s, bit w, bit [7:0] a, bit [31:0] d, string tag);
    bit [23:0] evt, clr;
    pin = cur_pins; sel = s; we = w; addr = a; wdata = d;
    #1;
    check("R8", {26'h0, irq}, {26'h0, b_irq()});
    if (s && !w) check(tag, rdata, b_read(a));
    @(posedge clk);
    for (int i = 0; i < 24; i++) evt[i] = b_hit(m_cfg[i], m_s2[i], m_prev[i]);
    clr = (s && w && a == 8'hA8) ? d[23:0] : 24'h0;
    m_pend = (m_pend & ~clr) | evt;
    if (s && w && a == 8'hA4) m_mask = d[23:0];
    if (s && w && (a == 8'h88 || a == 8'h8C || a == 8'h90))
      for (int k = 0; k < 8; k++) m_cfg[8*((a - 8'h88)/4) + k] = d[4*k +: 4];
    m_prev = m_s2; m_s2 = m_s1; m_s1 = cur_pins;
    @(negedge clk);
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d, string tag); cycle(1, 1, a, d, tag); endtask
  task automatic rd(bit [7:0] a, string tag); cycle(1, 0, a, 0, tag); endtask
  task automatic rdn(bit [7:0] a, int n, string tag);
    for (int i = 0; i < n; i++) rd(a, tag);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_s1 = '1; m_s2 = '1; m_prev = '1; m_pend = '0; m_mask = '1;
    for (int i = 0; i < 24; i++) m_cfg[i] = 4'd0;
    cur_pins = '1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(8'h88, "R10"); rd(8'h8C, "R10"); rd(8'h90, "R10");
    rd(8'hA4, "R10"); rd(8'hA8, "R10");

    // R1 field layout and readback
    wr(8'h8C, 32'hF0E2_5073, "R1"); rd(8'h8C, "R1");
    wr(8'h90, 32'h0000_0000, "R1"); rd(8'h90, "R1");
    wr(8'h8C, 32'h0, "R1"); wr(8'hA8, 32'hFFFFFF, "R1"); rd(8'hA8, "R1");
    wr(8'hA4, 32'h0, "R7");

    // R2 low level on line 0; clear while low does not stick
    cur_pins[0] = 0; rdn(8'hA8, 4, "R2");
    wr(8'hA8, 32'h1, "R2"); rdn(8'hA8, 2, "R2");
    cur_pins[0] = 1; rdn(8'hA8, 3, "R2");
    wr(8'hA8, 32'h1, "R2"); rdn(8'hA8, 2, "R2");

    // R3 high level on line 8 (group output)
    wr(8'h8C, 32'h1, "R3"); rdn(8'hA8, 3, "R3");
    cur_pins[8] = 0; rdn(8'hA8, 3, "R3");
    wr(8'hA8, 32'h100, "R3"); rdn(8'hA8, 2, "R3");

    // R9 latency, rising edge on line 1
    wr(8'h88, 32'h0000_0040, "R9");
    cur_pins[1] = 0; rdn(8'hA8, 3, "R9");
    cur_pins[1] = 1; rdn(8'hA8, 4, "R9");
    wr(8'hA8, 32'h2, "R9");

    // R4 falling on line 2, both on line 3
    wr(8'h88, 32'h0000_6240, "R4");
    cur_pins[2] = 0; cur_pins[3] = 0; rdn(8'hA8, 4, "R4");
    wr(8'hA8, 32'hC, "R4");
    cur_pins[2] = 1; cur_pins[3] = 1; rdn(8'hA8, 4, "R4");

    // R5 reserved codes on lines 4..7
    wr(8'hA8, 32'hFFFFFF, "R5");
    wr(8'h88, 32'hF753_6240, "R5");
    cur_pins[7:4] = 4'h0; rdn(8'hA8, 4, "R5");
    cur_pins[7:4] = 4'hF; rdn(8'hA8, 4, "R5");

    // R6 zero write ignored; clear and event on the same edge
    wr(8'h88, 32'h0000_6240, "R6");
    cur_pins[3] = 0; rdn(8'hA8, 4, "R6");
    wr(8'hA8, 32'h0, "R6"); rd(8'hA8, "R6");
    cur_pins[3] = 1; rd(8'hA8, "R6"); rd(8'hA8, "R6");
    wr(8'hA8, 32'h8, "R6"); rd(8'hA8, "R6");

    // R7 masked line still latches; unmasking exposes it
    wr(8'hA4, 32'hFFFFFF, "R7"); wr(8'hA8, 32'hFFFFFF, "R7");
    wr(8'h88, 32'h0040_0000, "R7");
    cur_pins[5] = 0; rdn(8'hA8, 2, "R7"); cur_pins[5] = 1; rdn(8'hA8, 4, "R7");
    wr(8'hA4, 32'hFFFF0F, "R7"); rd(8'hA4, "R7");

    // R8 group 8..23 via line 20
    wr(8'h90, 32'h0004_0000, "R8"); wr(8'hA4, 32'h0, "R8");
    cur_pins[20] = 0; rdn(8'hA8, 2, "R8"); cur_pins[20] = 1; rdn(8'hA8, 4, "R8");

    // R11 unmapped addresses
    wr(8'h00, 32'hFFFF_FFFF, "R11"); rd(8'h00, "R11"); rd(8'hFC, "R11");
    wr(8'hA4, 32'hFF00_0000, "R11"); rd(8'hA4, "R11"); rd(8'h94, "R11");

    // random phase
    for (int t = 0; t < 4000; t++) begin
      int op = $urandom_range(0, 15);
      if ($urandom_range(0, 3) == 0) cur_pins[$urandom_range(0, 23)] ^= 1'b1;
      case (op)
        0: wr(8'h88 + 8'(4 * $urandom_range(0, 2)), $urandom(), "R1");
        1: wr(8'hA4, $urandom(), "R7");
        2, 3: wr(8'hA8, $urandom(), "R6");
        4: rd(8'h88 + 8'(4 * $urandom_range(0, 2)), "R1");
        5: rd(8'hA4, "R7");
        6: rd(8'(32'hFC & $urandom()), "R11");
        default: rd(8'hA8, "R6");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule